// File: doc/BRIEF.md
# Output Compare Pin Controller

This block holds the pin side of a set of timer output compare channels. Each channel watches an externally supplied counter value and, on the counter tick where that value equals the channel's compare value, applies a programmed action to its own output pin and raises a sticky event flag. Software can also trigger the same pin action at any time through a one-cycle force strobe, which leaves the flag untouched. The enabled flags are merged into one interrupt line.

The counter itself, the register bus decode and any restart logic sit outside this block. The surrounding timer drives the count, the tick strobe and the per-channel settings. It turns a write of 1 to a flag bit into the clear strobe and a write of 1 to a force bit into the force strobe. A write of 0 to a force bit produces no strobe.

Top module: `ocmp_pin_ctrl`

## Requirements
- R1: While rst_ni is low, every output pin, every flag and irq_o are 0.
- R2: A channel matches only in a cycle where tick_i is 1 and cnt_i equals that channel's compare value. With tick_i at 0, an equal count changes neither pin nor flag, so a counter that holds its value does not retrigger.
- R3: Mode code 1 (toggle) inverts the channel's pin at the clock edge of a match or force.
- R4: Mode code 2 (clear) drives the channel's pin to 0 at the clock edge of a match or force.
- R5: Mode code 3 (set) drives the channel's pin to 1 at the clock edge of a match or force.
- R6: Mode code 0 and codes 4 to 7 leave the pin unchanged on a match or force, but a match still sets the flag.
- R7: A match sets the channel's flag at that clock edge, and the flag stays at 1 until it is cleared.
- R8: A 1 on a channel's flag_clr_i bit clears its flag at the next edge. If a match happens in the same cycle, the flag stays at 1.
- R9: A 1 on a channel's force_i bit applies the channel's pin action at the next edge without setting its flag. A force in the same cycle as a match applies the action once.
- R10: irq_o is the OR of all flags ANDed with their irq_en_i bits, and it follows those inputs in the same cycle.
- R11: Channel n takes its mode from mode_i[3n+2:3n] and its compare value from cmp_i[32n+31:32n]. Channels act independently, and several channels may act at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Current counter value |
| tick_i | input | 1 | Counter advanced this cycle |
| cmp_i | input | NUM_CH*CNT_W | Packed compare values, channel 0 in the low bits |
| mode_i | input | NUM_CH*3 | Packed pin action codes |
| force_i | input | NUM_CH | Force strobes, one per channel |
| flag_clr_i | input | NUM_CH | Flag clear strobes |
| irq_en_i | input | NUM_CH | Interrupt enables per flag |
| pin_o | output | NUM_CH | Compare output pins |
| flag_o | output | NUM_CH | Sticky compare flags |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its defaults: three channels and a 32-bit count. The counter is a plain input, so the bench can place a match at 32'hFFFF_FFFF directly, with no wait for a counter to roll through its range. Three channels are enough to give all three channels one compare value, so they all act at the same edge. They also allow each mode code to be set on one channel while the other two hold a different code, which shows up any slip in the packed mode slices.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
  localparam int unsigned ACT_W = 3;

  typedef enum logic [ACT_W-1:0] {
    ACT_OFF    = 3'd0,
    ACT_TOGGLE = 3'd1,
    ACT_CLEAR  = 3'd2,
    ACT_SET    = 3'd3
  } pin_act_e;
endpackage

// File: rtl/ocmp_match.sv
module ocmp_match #(
  parameter int unsigned CNT_W = 32
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             tick_i,
  output logic             hit_o
);
  // one hit per advancing tick; a stalled counter never re-hits
  assign hit_o = tick_i && (cnt_i == cmp_i);
endmodule

// File: rtl/ocmp_pin.sv
module ocmp_pin
  import ocmp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACT_W-1:0] mode_i,
  input  logic             fire_i,
  output logic             pin_o
);
  logic pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= 1'b0;
    end else if (fire_i) begin
      case (mode_i)
        ACT_TOGGLE: pin_q <= ~pin_q;
        ACT_CLEAR:  pin_q <= 1'b0;
        ACT_SET:    pin_q <= 1'b1;
        default:    pin_q <= pin_q;
      endcase
    end
  end

  assign pin_o = pin_q;

  a_r3_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && mode_i == ACT_TOGGLE) |=> (pin_o != $past(pin_o)));
  a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && mode_i == ACT_CLEAR) |=> !pin_o);
  a_r5_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && mode_i == ACT_SET) |=> pin_o);
  a_r6_no_action: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fire_i || mode_i == ACT_OFF || mode_i[2]) |=> $stable(pin_o));
endmodule

// File: rtl/ocmp_flag.sv
module ocmp_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // set dominates so an event in the clear cycle is not lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  a_r7_sticky_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  a_r7_sticky_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/ocmp_pin_ctrl.sv
module ocmp_pin_ctrl
  import ocmp_pkg::*;
#(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned CNT_W  = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic                    tick_i,
  input  logic [NUM_CH*CNT_W-1:0] cmp_i,
  input  logic [NUM_CH*ACT_W-1:0] mode_i,
  input  logic [NUM_CH-1:0]       force_i,
  input  logic [NUM_CH-1:0]       flag_clr_i,
  input  logic [NUM_CH-1:0]       irq_en_i,
  output logic [NUM_CH-1:0]       pin_o,
  output logic [NUM_CH-1:0]       flag_o,
  output logic                    irq_o
);
  logic [NUM_CH-1:0] hit;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ocmp_match #(.CNT_W(CNT_W)) i_match (
      .cnt_i  (cnt_i),
      .cmp_i  (cmp_i[c*CNT_W +: CNT_W]),
      .tick_i (tick_i),
      .hit_o  (hit[c])
    );

    // match and force in one cycle merge into a single action
    ocmp_pin i_pin (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .mode_i (mode_i[c*ACT_W +: ACT_W]),
      .fire_i (hit[c] | force_i[c]),
      .pin_o  (pin_o[c])
    );

    ocmp_flag i_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (hit[c]),
      .clr_i  (flag_clr_i[c]),
      .flag_o (flag_o[c])
    );

    a_r9_force_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (force_i[c] && !hit[c] && !flag_o[c]) |=> !flag_o[c]);
    a_r2_no_tick_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i && !flag_o[c]) |=> !flag_o[c]);
  end

  assign irq_o = |(flag_o & irq_en_i);

  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (pin_o == '0 && flag_o == '0 && !irq_o));
  a_r10_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i == '0) |-> !irq_o);
endmodule

// File: tb/test_ocmp_pin_ctrl.sv
module test_ocmp_pin_ctrl;
  localparam int unsigned NUM_CH = 3;
  localparam int unsigned CNT_W  = 32;

  logic                    clk_i = 1'b0;
  logic                    rst_ni = 1'b0;
  logic [CNT_W-1:0]        cnt_i = '0;
  logic                    tick_i = 1'b0;
  logic [NUM_CH*CNT_W-1:0] cmp_i = '0;
  logic [NUM_CH*3-1:0]     mode_i = '0;
  logic [NUM_CH-1:0]       force_i = '0;
  logic [NUM_CH-1:0]       flag_clr_i = '0;
  logic [NUM_CH-1:0]       irq_en_i = '0;
  logic [NUM_CH-1:0]       pin_o;
  logic [NUM_CH-1:0]       flag_o;
  logic                    irq_o;

  always #5 clk_i = ~clk_i;

  ocmp_pin_ctrl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) i_ocmp_pin_ctrl (
    .clk_i, .rst_ni, .cnt_i, .tick_i, .cmp_i, .mode_i, .force_i,
    .flag_clr_i, .irq_en_i, .pin_o, .flag_o, .irq_o
  );

  typedef struct {
    logic [NUM_CH-1:0] pin;
    logic [NUM_CH-1:0] flag;
    logic              irq;
    string             tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;

  // reference state, derived from the requirements
  logic [2:0]        m_mode [NUM_CH];
  logic [CNT_W-1:0]  m_cmp  [NUM_CH];
  logic [NUM_CH-1:0] m_en   = '0;
  logic [NUM_CH-1:0] m_pin  = '0;
  logic [NUM_CH-1:0] m_flag = '0;

  task automatic step(input logic [CNT_W-1:0] cnt, input logic tick,
                      input logic [NUM_CH-1:0] frc, input logic [NUM_CH-1:0] clr,
                      input string tag);
    exp_t e;
    @(negedge clk_i);
    cnt_i      = cnt;
    tick_i     = tick;
    force_i    = frc;
    flag_clr_i = clr;
    irq_en_i   = m_en;
    for (int c = 0; c < NUM_CH; c++) begin
      logic hit;
      cmp_i[c*CNT_W +: CNT_W] = m_cmp[c];
      mode_i[c*3 +: 3]        = m_mode[c];
      hit = tick && (cnt == m_cmp[c]);
      if (hit || frc[c]) begin
        if (m_mode[c] == 3'd1)      m_pin[c] = ~m_pin[c];
        else if (m_mode[c] == 3'd2) m_pin[c] = 1'b0;
        else if (m_mode[c] == 3'd3) m_pin[c] = 1'b1;
      end
      if (hit)         m_flag[c] = 1'b1;
      else if (clr[c]) m_flag[c] = 1'b0;
    end
    e.pin  = m_pin;
    e.flag = m_flag;
    e.irq  = |(m_flag & m_en);
    e.tag  = tag;
    q.push_back(e);
  endtask

  // monitor: compare a little after each active edge
  always @(posedge clk_i) begin
    exp_t e;
    #2;
    if (q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if (pin_o !== e.pin || flag_o !== e.flag || irq_o !== e.irq) begin
        fails++;
        $display("FAIL %s: pin=%b flag=%b irq=%b expected pin=%b flag=%b irq=%b",
                 e.tag, pin_o, flag_o, irq_o, e.pin, e.flag, e.irq);
      end
    end
  end

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog expired, run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < NUM_CH; c++) begin
      m_mode[c] = 3'd0;
      m_cmp[c]  = '0;
    end
    #12;
    checks++;  // R1
    if (pin_o !== '0 || flag_o !== '0 || irq_o !== 1'b0) begin
      fails++;
      $display("FAIL R1: pin=%b flag=%b irq=%b expected all zero", pin_o, flag_o, irq_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;

    m_cmp[0] = 32'd10; m_cmp[1] = 32'd20; m_cmp[2] = 32'd30;
    m_mode[0] = 3'd1; m_mode[1] = 3'd3; m_mode[2] = 3'd2;
    step(32'd10, 1'b0, 3'b000, 3'b000, "R2 equal count without tick");
    step(32'd10, 1'b1, 3'b000, 3'b000, "R3 toggle on match, R7 flag set");
    step(32'd10, 1'b0, 3'b000, 3'b000, "R2 holding counter no retrigger");
    step(32'd11, 1'b1, 3'b000, 3'b000, "R7 flag stays sticky");
    step(32'd20, 1'b1, 3'b000, 3'b000, "R5 set on match, R11 channel 1 only");
    m_mode[2] = 3'd3;
    step(32'd0, 1'b0, 3'b100, 3'b000, "R9 force applies set without flag");
    m_mode[2] = 3'd2;
    step(32'd30, 1'b1, 3'b000, 3'b000, "R4 clear on match");
    step(32'd31, 1'b1, 3'b000, 3'b001, "R8 flag clear");
    step(32'd10, 1'b1, 3'b000, 3'b001, "R8 match wins over clear");
    m_en = 3'b010;
    step(32'd12, 1'b0, 3'b000, 3'b000, "R10 enabled flag raises irq");
    m_en = 3'b000;
    step(32'd12, 1'b0, 3'b000, 3'b000, "R10 masked flags give no irq");
    step(32'd0, 1'b0, 3'b000, 3'b111, "R8 clear all flags");
    m_mode[0] = 3'd0;
    step(32'd10, 1'b1, 3'b000, 3'b000, "R6 code 0 keeps pin, sets flag");
    m_mode[0] = 3'd5;
    step(32'd10, 1'b1, 3'b000, 3'b001, "R6 code 5 keeps pin");
    m_mode[0] = 3'd6;
    step(32'd0, 1'b0, 3'b001, 3'b000, "R6 code 6 force keeps pin");
    m_mode[0] = 3'd1;
    step(32'd10, 1'b1, 3'b001, 3'b001, "R9 force with match toggles once");
    step(32'd0, 1'b0, 3'b000, 3'b111, "R8 clear before shared match");
    m_cmp[0] = 32'hFFFF_FFFF; m_cmp[1] = 32'hFFFF_FFFF; m_cmp[2] = 32'hFFFF_FFFF;
    m_mode[0] = 3'd1; m_mode[1] = 3'd2; m_mode[2] = 3'd3;
    m_en = 3'b100;
    step(32'hFFFF_FFFF, 1'b1, 3'b000, 3'b000, "R11 all channels at top count");
    m_mode[0] = 3'd3; m_mode[1] = 3'd1; m_mode[2] = 3'd0;
    step(32'd0, 1'b0, 3'b111, 3'b011, "R11 packed mode slices under force");
    step(32'd0, 1'b0, 3'b000, 3'b000, "R9 no force no change");

    @(negedge clk_i);
    @(negedge clk_i);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule